// File: doc/BRIEF.md
# Multi-lane deterministic traffic generator

This block feeds a streaming source interface with test traffic that a far-end checker can verify without any shared state. On every accepted beat it presents one 64-bit sample word per lane. Each word is self-describing: it names the lane position it was placed on, the burst it belongs to, and a running count of beats sent since reset. A receiver can therefore detect swapped lanes, lost or repeated beats, and lanes that were de-skewed wrongly, because every lane of one beat carries identical counters.

Two traffic shapes are offered. In burst mode the beats are grouped into bursts of a programmable length, framed by start and end markers. In continuous mode a single unframed stream runs for as long as the block is enabled. Mode and burst length are taken in only while the generator is idle. Removing the enable in burst mode lets the running burst complete before the stream stops, so a receiver never sees a truncated burst. Handshaking follows the usual valid/ready rule: a beat is transferred on a clock edge where both are high.

Top module: `lane_traffic_gen`

## Requirements
- R1: While `rst` is high and after it is released with `en_i` low, `vld_o`, `sob_o` and `eob_o` are low; the first beat sent after reset carries burst count 1 and word count 1.
- R2: Lane l occupies `data_o[64*l+63 : 64*l]`; in it bits 63:59 hold the value l, bits 58:32 the burst count and bits 31:0 the word count, and every lane of a beat carries the same burst count and word count.
- R3: The word count of each accepted beat is one higher (modulo 2^32) than that of the previous accepted beat; bursts, mode changes and enable changes never clear it.
- R4: In burst mode (`cont_mode_i` = 0) beats come in bursts of L beats; `sob_o` marks the first beat and `eob_o` the last (both on the same beat when L = 1), and each new burst carries a burst count one higher than the burst before it.
- R5: A `burst_len_i` value of 0 is treated as a length of 1.
- R6: While `vld_o` is high and `rdy_i` is low, `vld_o`, `data_o`, `sob_o` and `eob_o` hold their values and no counter advances.
- R7: If `en_i` drops during a burst, the generator still delivers the remaining beats of that burst up to and including its end beat, then lowers `vld_o`.
- R8: In continuous mode (`cont_mode_i` = 1) `sob_o` and `eob_o` stay low, the burst count does not change, and `vld_o` falls after the first accepted beat at whose edge `en_i` is low.
- R9: `cont_mode_i` and `burst_len_i` are sampled only on edges where `vld_o` is low; changes while `vld_o` is high have no effect on the running traffic.
- R10: `sob_o` and `eob_o` are never high while `vld_o` is low, and `sob_o` never rises inside an unfinished burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run request |
| cont_mode_i | input | 1 | 1 = continuous stream, 0 = bursts |
| burst_len_i | input | LEN_W | Beats per burst (0 means 1) |
| rdy_i | input | 1 | Sink can take a beat |
| vld_o | output | 1 | Beat on `data_o` is valid |
| sob_o | output | 1 | First beat of a burst |
| eob_o | output | 1 | Last beat of a burst |
| data_o | output | LANES*64 | One sample word per lane |

## Verification
The bench builds the generator with three lanes and a 6-bit length field, so lane identifiers 0, 1 and 2 must all appear in distinct positions and a lane swap shows up at once, while burst lengths of 0, 1, 3, 4 and 5 stay short enough to run many bursts back to back. Three lanes rather than a power of two also exercise the lane-offset arithmetic of the packing. Ready patterns of always-high, alternating and two-in-three reach stalls on start, middle and end beats, and the run that changes mode and length inputs mid-stream shows they are ignored until the block is idle.

// File: rtl/ltg_pkg.sv
package ltg_pkg;

  // fixed sample-word layout (receivers decode these positions)
  localparam int WORD_W = 64;
  localparam int ID_W   = 5;
  localparam int BCNT_W = 27;
  localparam int WCNT_W = 32;

  typedef logic [BCNT_W-1:0] bcnt_t;
  typedef logic [WCNT_W-1:0] wcnt_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    bcnt_t           bcnt;
    wcnt_t           wcnt;
  } lane_word_t;

  function automatic lane_word_t make_word(input int unsigned lane,
                                           input bcnt_t b, input wcnt_t w);
    lane_word_t r;
    r.id   = ID_W'(lane);
    r.bcnt = b;
    r.wcnt = w;
    return r;
  endfunction

endpackage

// File: rtl/ltg_cfg.sv
// Holds mode and burst length; the registers follow the inputs only while
// the generator is idle, and the effective value bypasses on that cycle.
module ltg_cfg #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             mode_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             mode_eff,
  output logic [LEN_W-1:0] len_eff
);
  logic             mode_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_fix;

  assign len_fix  = (len_in == '0) ? LEN_W'(1) : len_in;
  assign mode_eff = load ? mode_in : mode_q;
  assign len_eff  = load ? len_fix : len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      len_q  <= LEN_W'(1);
    end else if (load) begin
      mode_q <= mode_in;
      len_q  <= len_fix;
    end
  end
endmodule

// File: rtl/ltg_seq.sv
// Beat sequencer: owns valid and the burst markers.
module ltg_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rdy,
  input  logic             cont,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] idx,
  output logic             vld,
  output logic             sob,
  output logic             eob,
  output logic             load,
  output logic             fire
);
  localparam int XW = LEN_W + 1;

  logic vld_q, sob_q, eob_q;
  logic len_one;
  logic next_last;

  assign len_one   = (len == LEN_W'(1));
  // the beat after the current one is the last when idx + 2 == len
  assign next_last = (({1'b0, idx} + XW'(2)) == {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      sob_q <= 1'b0;
      eob_q <= 1'b0;
    end else if (!vld_q) begin
      if (en) begin
        vld_q <= 1'b1;
        sob_q <= !cont;
        eob_q <= !cont && len_one;
      end
    end else if (rdy) begin
      if (cont) begin
        vld_q <= en;
        sob_q <= 1'b0;
        eob_q <= 1'b0;
      end else if (eob_q) begin
        vld_q <= en;
        sob_q <= en;
        eob_q <= en && len_one;
      end else begin
        vld_q <= 1'b1;
        sob_q <= 1'b0;
        eob_q <= next_last;
      end
    end
  end

  assign vld  = vld_q;
  assign sob  = sob_q;
  assign eob  = eob_q;
  assign load = !vld_q;
  assign fire = vld_q && rdy;
endmodule

// File: rtl/ltg_count.sv
// Position-in-burst, burst and word counters for the presented beat.
module ltg_count
  import ltg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             cont,
  input  logic             last,
  output logic [LEN_W-1:0] idx,
  output bcnt_t            bcnt,
  output wcnt_t            wcnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      bcnt <= bcnt_t'(1);
      wcnt <= wcnt_t'(1);
    end else if (fire) begin
      wcnt <= wcnt + wcnt_t'(1);
      if (!cont) begin
        if (last) begin
          idx  <= '0;
          bcnt <= bcnt + bcnt_t'(1);
        end else begin
          idx <= idx + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ltg_pack.sv
// Places one self-describing word on every lane.
module ltg_pack
  import ltg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  bcnt_t                     bcnt,
  input  wcnt_t                     wcnt,
  output logic [LANES*WORD_W-1:0]   data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data[l*WORD_W +: WORD_W] = make_word(l, bcnt, wcnt);
  end
endmodule

// File: rtl/lane_traffic_gen.sv
module lane_traffic_gen
  import ltg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LEN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    cont_mode_i,
  input  logic [LEN_W-1:0]        burst_len_i,
  input  logic                    rdy_i,
  output logic                    vld_o,
  output logic                    sob_o,
  output logic                    eob_o,
  output logic [LANES*WORD_W-1:0] data_o
);
  logic             load, fire, cont;
  logic [LEN_W-1:0] len, idx;
  bcnt_t            bcnt;
  wcnt_t            wcnt;

  ltg_cfg #(.LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .mode_in(cont_mode_i), .len_in(burst_len_i),
    .mode_eff(cont), .len_eff(len)
  );

  ltg_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .en(en_i), .rdy(rdy_i),
    .cont(cont), .len(len), .idx(idx),
    .vld(vld_o), .sob(sob_o), .eob(eob_o),
    .load(load), .fire(fire)
  );

  ltg_count #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .fire(fire), .cont(cont), .last(eob_o),
    .idx(idx), .bcnt(bcnt), .wcnt(wcnt)
  );

  ltg_pack #(.LANES(LANES)) u_pack (
    .bcnt(bcnt), .wcnt(wcnt), .data(data_o)
  );
endmodule

// File: rtl/ltg_chk.sv
module ltg_chk
  import ltg_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rdy_i,
  input logic                    vld_o,
  input logic                    sob_o,
  input logic                    eob_o,
  input logic [LANES*WORD_W-1:0] data_o
);
  logic  in_burst;
  logic  acc;
  bcnt_t b0;
  wcnt_t w0;

  assign acc = vld_o && rdy_i;
  assign b0  = data_o[WCNT_W +: BCNT_W];
  assign w0  = data_o[0 +: WCNT_W];

  always_ff @(posedge clk) begin
    if (rst)                      in_burst <= 1'b0;
    else if (acc && eob_o)        in_burst <= 1'b0;
    else if (acc && sob_o)        in_burst <= 1'b1;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o && !rdy_i |=> vld_o && $stable(data_o) && $stable(sob_o) && $stable(eob_o));

  // R3
  wcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> w0 == $past(w0) + wcnt_t'(1));

  // R4
  bcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    acc && eob_o |=> b0 == $past(b0) + bcnt_t'(1));

  // R8
  bcnt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !eob_o |=> $stable(b0));

  // R7
  burst_finish_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !eob_o && (sob_o || in_burst) |=> vld_o);

  // R10
  marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> !sob_o && !eob_o);

  // R10
  no_nested_sob_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o && in_burst |-> !sob_o);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R2
    lane_fields_chk: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> data_o[l*WORD_W + 59 +: ID_W] == ID_W'(l)
             && data_o[l*WORD_W +: 59] == data_o[0 +: 59]);
  end
endmodule

bind lane_traffic_gen ltg_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .rdy_i(rdy_i), .vld_o(vld_o),
  .sob_o(sob_o), .eob_o(eob_o), .data_o(data_o)
);

// File: tb/test_lane_traffic_gen.sv
`timescale 1ns/1ps
module test_lane_traffic_gen;
  import ltg_pkg::*;

  localparam int LANES = 3;
  localparam int LEN_W = 6;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    en_i = 1'b0;
  logic                    cont_mode_i = 1'b0;
  logic [LEN_W-1:0]        burst_len_i = '0;
  logic                    rdy_i = 1'b0;
  logic                    vld_o, sob_o, eob_o;
  logic [LANES*WORD_W-1:0] data_o;

  lane_traffic_gen #(.LANES(LANES), .LEN_W(LEN_W)) i_lane_traffic_gen (
    .clk(clk), .rst(rst), .en_i(en_i), .cont_mode_i(cont_mode_i),
    .burst_len_i(burst_len_i), .rdy_i(rdy_i), .vld_o(vld_o),
    .sob_o(sob_o), .eob_o(eob_o), .data_o(data_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic  sob;
    logic  eob;
    bcnt_t b;
    wcnt_t w;
    bit    cont;
  } exp_t;

  exp_t  q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    acc_cnt = 0;
  bcnt_t m_b = bcnt_t'(1);
  wcnt_t m_w = wcnt_t'(1);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: samples at the falling edge
  logic                    p_vld = 1'b0, p_rdy = 1'b0, p_sob = 1'b0, p_eob = 1'b0;
  logic [LANES*WORD_W-1:0] p_data = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_vld && !p_rdy)
        check(vld_o && data_o == p_data && sob_o == p_sob && eob_o == p_eob,
              "R6", "stalled beat changed", {61'd0, vld_o, sob_o, eob_o},
              {61'd0, 1'b1, p_sob, p_eob});
      if (!vld_o)
        check(!sob_o && !eob_o, "R10", "marker without valid",
              {62'd0, sob_o, eob_o}, 64'd0);
      if (vld_o && rdy_i) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected beat", data_o[63:0], 64'd0);
        end else begin
          exp_t  e;
          string rq;
          e  = q.pop_front();
          rq = e.cont ? "R8" : "R4";
          if (acc_cnt == 0)
            check(data_o[0 +: 59] == {27'd1, 32'd1}, "R1", "first beat counts",
                  {5'd0, data_o[0 +: 59]}, {5'd0, 27'd1, 32'd1});
          for (int l = 0; l < LANES; l++) begin
            lane_word_t lw;
            lw = data_o[l*WORD_W +: WORD_W];
            check(lw.id == ID_W'(l), "R2", "lane id", 64'(lw.id), 64'(l));
            check(lw.wcnt == e.w, "R3", "word count", 64'(lw.wcnt), 64'(e.w));
            check(lw.bcnt == e.b, rq, "burst count", 64'(lw.bcnt), 64'(e.b));
          end
          check(sob_o == e.sob && eob_o == e.eob, rq, "markers",
                {62'd0, sob_o, eob_o}, {62'd0, e.sob, e.eob});
        end
        acc_cnt++;
      end
    end
    p_vld  = vld_o;
    p_rdy  = rdy_i;
    p_sob  = sob_o;
    p_eob  = eob_o;
    p_data = data_o;
  end

  // driver: pushes the expected beats, then runs the handshake
  task automatic run(input bit cont, input int len_in, input int n,
                     input int rpat, input bit scramble);
    int L, target, started, sent, cyc;
    L = (len_in == 0) ? 1 : len_in;  // R5
    if (cont) begin
      for (int i = 0; i < n; i++) begin
        q.push_back('{1'b0, 1'b0, m_b, m_w, 1'b1});
        m_w++;
      end
    end else begin
      for (int b = 0; b < n; b++) begin
        for (int i = 0; i < L; i++) begin
          q.push_back('{i == 0, i == L-1, m_b, m_w, 1'b0});
          m_w++;
        end
        m_b++;
      end
    end
    target  = acc_cnt + (cont ? n : n * L);
    started = 0;
    sent    = 0;
    cyc     = 0;
    cont_mode_i = cont;
    burst_len_i = LEN_W'(len_in);
    en_i        = 1'b1;
    while (en_i) begin
      @(posedge clk); #1;
      cyc++;
      if (scramble && vld_o) begin  // R9: must be ignored
        cont_mode_i = ~cont;
        burst_len_i = LEN_W'(len_in + 3);
      end
      rdy_i = (rpat == 0) ? 1'b1 : ((cyc % rpat) != 0);
      if (!cont) begin
        if (vld_o && sob_o && rdy_i) begin
          started++;
          if (started == n) en_i = 1'b0;  // R7: drop during last burst
        end
      end else if (vld_o && rdy_i) begin
        sent++;
        if (sent == n) en_i = 1'b0;
      end
    end
    while (acc_cnt < target) begin
      @(posedge clk); #1;
      cyc++;
      rdy_i = (rpat == 0) ? 1'b1 : ((cyc % rpat) != 0);
    end
    rdy_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!vld_o, cont ? "R8" : "R7", "valid after stop", 64'(vld_o), 64'd0);
    check(q.size() == 0, "R3", "beats missing", 64'(q.size()), 64'd0);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vld_o && !sob_o && !eob_o, "R1", "outputs in reset",
          {61'd0, vld_o, sob_o, eob_o}, 64'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vld_o && !sob_o && !eob_o, "R1", "idle after reset",
          {61'd0, vld_o, sob_o, eob_o}, 64'd0);
    @(posedge clk); #1;
    run(1'b1, 4, 10, 0, 1'b0);   // R8 continuous straight from reset
    run(1'b0, 4, 3, 0, 1'b0);    // R4 bursts of four
    run(1'b0, 3, 2, 2, 1'b1);    // R6 R9 alternating ready, inputs scrambled
    run(1'b0, 0, 3, 3, 1'b0);    // R5 length zero
    run(1'b1, 2, 7, 2, 1'b1);    // R8 R9 continuous after bursts
    run(1'b0, 5, 2, 3, 1'b0);    // R7 R3 stalls inside bursts
    finish_run();
  end
endmodule